// File: doc/BRIEF.md
# Page write buffer with timed commit

This block sits behind the serial protocol engine of a byte-wide nonvolatile store. The engine hands it a word address, then one strobe per received data byte. The block keeps these bytes in a one-page staging buffer. Each byte has its own occupancy flag. The address counter steps only inside the current page, so a long burst folds back onto the first byte of the same page and replaces what was staged there.

Nothing reaches the storage array while bytes are arriving. When the engine reports the stop that closes the transaction, the block checks two things: at least one byte must be staged, and write-protect must be low. If both hold, the block raises busy for a fixed number of clocks, set by a parameter. During that window it walks the page offsets in ascending order and presents each staged byte on the array write port. Every request that arrives while busy is high is dropped. A start condition that arrives before a stop abandons the staged bytes. The engine reads the updated address counter back for current-address reads.

Top module: `page_commit_buffer`

## Requirements
- R1: After reset, busy is 0, the array write enable is 0 and the address counter is 0.
- R2: While busy is low, an address-load strobe places the 16-bit word address in the address counter on the next clock.
- R3: Each accepted data byte is staged at the page offset given by the counter's low 7 bits. The counter then advances with only those 7 bits incrementing: offset 127 is followed by offset 0, and bits 15..7 (the page) are unchanged.
- R4: When one transaction writes the same offset twice, the later byte replaces the earlier one, so at most 128 distinct bytes are committed.
- R5: The array write enable is never asserted while busy is low, so no staged byte reaches the array before the stop.
- R6: A stop accepted while at least one byte is staged and write-protect is low raises busy on the next clock. Busy then stays high for exactly COMMIT_CYCLES clocks.
- R7: During the commit window, each staged offset is written exactly once, in ascending offset order, at address {page, offset}, with the last byte staged there. Unstaged offsets are not written.
- R8: While busy is high, address-load, data, stop and start strobes have no effect on the counter, the staged bytes or the commit.
- R9: While write-protect is high, the array write enable stays 0. A stop accepted with write-protect high starts no commit and discards the staged bytes.
- R10: A start strobe accepted before the stop discards the staged bytes, and a following stop starts no commit.
- R11: A data byte and a stop in the same cycle are handled as the byte followed by the stop: that byte is committed.
- R12: When a commit ends, all occupancy flags are clear, so a later stop with no new data starts no commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_load | input | 1 | Load word address strobe |
| addr_in | input | 16 | Word address to load |
| byte_valid | input | 1 | Received data byte strobe |
| byte_data | input | 8 | Received data byte |
| stop_strobe | input | 1 | Stop condition closing the transaction |
| start_strobe | input | 1 | Start condition seen before a stop |
| wp | input | 1 | Write protect, high blocks all array writes |
| busy | output | 1 | Commit window in progress |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | 16 | Array write address |
| arr_wdata | output | 8 | Array write data |
| addr_cnt | output | 16 | Current address counter for the protocol engine |

## Verification
Two pairs of events can fall in the same cycle. The first is a data byte and the stop that ends the transaction. The bench drives both strobes together and expects the byte to appear in the commit (R11). The second is write-protect rising while a commit is already walking the page. The bench raises it one cycle into a four-byte commit and expects exactly one array write, with busy still running its full length. Each cycle, a behavioural page model in the bench predicts busy, the counter and every array write, and the bench compares the design against that prediction.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
  // Advance an address by one inside its page: low off_w bits wrap, upper bits stay.
  function automatic logic [31:0] in_page_next(logic [31:0] a, int unsigned off_w);
    logic [31:0] m;
    m = (32'd1 << off_w) - 32'd1;
    return (a & ~m) | ((a + 32'd1) & m);
  endfunction

  // A commit may start only with staged data and protection off.
  function automatic logic commit_ok(logic have_bytes, logic prot);
    return have_bytes & ~prot;
  endfunction
endpackage

// File: rtl/pgbuf_store.sv
module pgbuf_store #(
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 128,
  localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [OFF_W-1:0]  rd_off,
  output logic              any_valid,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0]     slot [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] occ;

  always_ff @(posedge clk) begin
    if (wr_en) slot[wr_off] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     occ <= '0;
    else if (clr)   occ <= '0;
    else if (wr_en) occ[wr_off] <= 1'b1;
  end

  assign any_valid = |occ;
  assign rd_valid  = occ[rd_off];
  assign rd_data   = slot[rd_off];

  // R12: a clear request leaves the page empty
  p_clear_empties_r12: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !any_valid);
endmodule

// File: rtl/pgbuf_timer.sv
module pgbuf_timer #(
  parameter int COMMIT_CYCLES = 625000,
  parameter int PAGE_BYTES    = 128,
  localparam int CNT_W  = $clog2(COMMIT_CYCLES + 1),
  localparam int SCAN_W = $clog2(PAGE_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  output logic              busy,
  output logic [SCAN_W-1:0] scan,
  output logic              done
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(COMMIT_CYCLES - 1);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      scan <= '0;
    end else if (go) begin
      busy <= 1'b1;
      cnt  <= '0;
      scan <= '0;
    end else if (busy) begin
      if (cnt == LAST) busy <= 1'b0;
      else             cnt  <= cnt + 1'b1;
      if (!scan[SCAN_W-1]) scan <= scan + 1'b1;
    end
  end

  assign done = busy && (cnt == LAST);

  // R6: busy keeps running until the last count
  p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  // R6: busy only rises from a commit request
  p_busy_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(go));
  // R8: no new commit is requested during a commit
  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy);
endmodule

// File: rtl/page_commit_buffer.sv
module page_commit_buffer #(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 8,
  parameter int PAGE_BYTES    = 128,
  parameter int COMMIT_CYCLES = 625000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              stop_strobe,
  input  logic              start_strobe,
  input  logic              wp,
  output logic              busy,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata,
  output logic [ADDR_W-1:0] addr_cnt
);
  import pgbuf_pkg::*;

  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int SCAN_W = OFF_W + 1;

  logic [ADDR_W-1:0] addr_q;
  logic              take_start, take_load, take_byte, take_stop;
  logic              pend_any, go, discard, done;
  logic              any_valid, rd_valid;
  logic [SCAN_W-1:0] scan;
  logic [OFF_W-1:0]  rd_off;
  logic [DATA_W-1:0] rd_data;

  // request acceptance: all requests drop while busy; start beats everything
  assign take_start = !busy && start_strobe;
  assign take_load  = !busy && !start_strobe && addr_load;
  assign take_byte  = !busy && !start_strobe && !addr_load && byte_valid;
  assign take_stop  = !busy && !start_strobe && stop_strobe;

  assign pend_any = !take_load && (any_valid || take_byte);
  assign go       = take_stop && commit_ok(pend_any, wp);
  assign discard  = take_start || take_load || (take_stop && !go) || done;

  always_ff @(posedge clk) begin
    if (!rst_n)         addr_q <= '0;
    else if (take_load) addr_q <= addr_in;
    else if (take_byte) addr_q <= ADDR_W'(in_page_next(32'(addr_q), OFF_W));
  end

  pgbuf_store #(.DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)) store_i (
    .clk(clk), .rst_n(rst_n), .clr(discard),
    .wr_en(take_byte), .wr_off(addr_q[OFF_W-1:0]), .wr_data(byte_data),
    .rd_off(rd_off), .any_valid(any_valid), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  pgbuf_timer #(.COMMIT_CYCLES(COMMIT_CYCLES), .PAGE_BYTES(PAGE_BYTES)) timer_i (
    .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .scan(scan), .done(done)
  );

  assign rd_off    = scan[OFF_W-1:0];
  assign arr_we    = busy && !scan[OFF_W] && rd_valid && !wp;
  assign arr_addr  = {addr_q[ADDR_W-1:OFF_W], rd_off};
  assign arr_wdata = rd_data;
  assign addr_cnt  = addr_q;

  // R5: array is written only inside a commit window
  p_we_in_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);
  // R9: protection blocks the array port
  p_we_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wp |-> !arr_we);
  // R3: a byte never moves the counter to another page
  p_page_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(take_byte) |-> addr_q[ADDR_W-1:OFF_W] == $past(addr_q[ADDR_W-1:OFF_W]));
  // R8: the counter holds while a commit runs
  p_hold_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(addr_q));
  // R12: a finished commit leaves no staged bytes
  p_empty_after_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !any_valid);
endmodule

// File: tb/page_commit_buffer_tb_top.sv
module page_commit_buffer_tb_top;
  localparam int CYC  = 150;
  localparam int PAGE = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_load = 1'b0, byte_valid = 1'b0, stop_strobe = 1'b0, start_strobe = 1'b0, wp = 1'b0;
  logic [15:0] addr_in = '0;
  logic [7:0]  byte_data = '0;
  logic busy, arr_we;
  logic [15:0] arr_addr, addr_cnt;
  logic [7:0]  arr_wdata;

  always #4 clk = ~clk;

  page_commit_buffer #(.COMMIT_CYCLES(CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
    .byte_valid(byte_valid), .byte_data(byte_data), .stop_strobe(stop_strobe),
    .start_strobe(start_strobe), .wp(wp), .busy(busy), .arr_we(arr_we),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata), .addr_cnt(addr_cnt)
  );

  int nchk = 0, nfail = 0, wcount = 0, ncyc = 0;
  logic [7:0] seen [int];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural page model
  bit        mbusy;
  int        mcnt, mscan;
  int        maddr;
  bit        mvalid [PAGE];
  logic [7:0] mdata [PAGE];
  bit        live = 1'b0;

  function automatic void mclear();
    foreach (mvalid[i]) mvalid[i] = 1'b0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mbusy = 0; mcnt = 0; mscan = 0; maddr = 0; mclear();
    end else if (mbusy) begin
      if (mcnt == CYC - 1) begin mbusy = 0; mclear(); end
      else mcnt++;
      if (mscan < PAGE) mscan++;
    end else if (start_strobe) begin
      mclear();
    end else begin
      bit any;
      if (addr_load) begin
        maddr = int'(addr_in); mclear();
      end else if (byte_valid) begin
        mdata[maddr % PAGE] = byte_data;
        mvalid[maddr % PAGE] = 1'b1;
        maddr = (maddr / PAGE) * PAGE + ((maddr + 1) % PAGE);
      end
      if (stop_strobe) begin
        any = 0;
        foreach (mvalid[i]) any |= mvalid[i];
        if (any && !wp) begin mbusy = 1; mcnt = 0; mscan = 0; end
        else mclear();
      end
    end
  end

  // compare every cycle, away from both edges
  always @(negedge clk) begin
    #2;
    if (live) begin
      bit ewe;
      ewe = mbusy && mscan < PAGE && mvalid[mscan % PAGE] && !wp;
      chk("R6 R8 busy", 32'(busy), 32'(mbusy));
      chk("R2 R3 addr_cnt", 32'(addr_cnt), 32'(maddr));
      chk("R5 R7 R9 arr_we", 32'(arr_we), 32'(ewe));
      if (ewe && arr_we) begin
        chk("R7 arr_addr", 32'(arr_addr), 32'((maddr / PAGE) * PAGE + mscan));
        chk("R4 R7 arr_wdata", 32'(arr_wdata), 32'(mdata[mscan]));
      end
      if (arr_we) begin
        seen[int'(arr_addr)] = arr_wdata;
        wcount++;
      end
    end
  end

  always @(posedge clk) begin
    ncyc++;
    if (ncyc == 150000) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=done", ncyc);
      $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

  task automatic drv(bit ld, logic [15:0] a, bit bv, logic [7:0] d, bit sp, bit st);
    @(negedge clk);
    addr_load = ld; addr_in = a; byte_valid = bv; byte_data = d;
    stop_strobe = sp; start_strobe = st;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drv(0, '0, 0, '0, 0, 0);
  endtask

  initial begin
    int w0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk("R1 busy", 32'(busy), 0);
    chk("R1 arr_we", 32'(arr_we), 0);
    chk("R1 addr_cnt", 32'(addr_cnt), 0);
    live = 1'b1;

    // short write inside one page
    w0 = wcount;
    drv(1, 16'h1234, 0, 0, 0, 0);
    drv(0, 0, 1, 8'hA1, 0, 0);
    drv(0, 0, 1, 8'hA2, 0, 0);
    drv(0, 0, 1, 8'hA3, 0, 0);
    drv(0, 0, 0, 0, 1, 0);
    idle(CYC + 5);
    chk("R7 write count", 32'(wcount - w0), 3);
    chk("R7 first byte", 32'(seen[16'h1234]), 32'hA1);
    chk("R7 last byte", 32'(seen[16'h1236]), 32'hA3);
    chk("R2 counter after commit", 32'(addr_cnt), 32'h1237);

    // 130 bytes fold back over the page start
    w0 = wcount;
    drv(1, 16'h0A00, 0, 0, 0, 0);
    for (int i = 0; i < 130; i++) drv(0, 0, 1, 8'(i), 0, 0);
    drv(0, 0, 0, 0, 1, 0);
    idle(CYC + 5);
    chk("R4 write count", 32'(wcount - w0), 128);
    chk("R4 offset0 overwritten", 32'(seen[16'h0A00]), 32'h80);
    chk("R4 offset1 overwritten", 32'(seen[16'h0A01]), 32'h81);
    chk("R3 offset127", 32'(seen[16'h0A7F]), 32'h7F);
    chk("R3 page kept", 32'(addr_cnt), 32'h0A02);

    // requests during busy are ignored
    w0 = wcount;
    drv(1, 16'h2000, 0, 0, 0, 0);
    drv(0, 0, 1, 8'h11, 0, 0);
    drv(0, 0, 0, 0, 1, 0);
    drv(1, 16'h3333, 1, 8'h55, 1, 0);
    drv(0, 0, 1, 8'h66, 0, 1);
    idle(CYC + 5);
    chk("R8 counter", 32'(addr_cnt), 32'h2001);
    chk("R8 write count", 32'(wcount - w0), 1);
    chk("R8 data", 32'(seen[16'h2000]), 32'h11);
    drv(0, 0, 0, 0, 1, 0);
    idle(2);
    chk("R12 empty stop", 32'(busy), 0);

    // write protect at stop
    w0 = wcount;
    @(negedge clk) wp = 1'b1;
    drv(1, 16'h4000, 0, 0, 0, 0);
    drv(0, 0, 1, 8'h77, 0, 0);
    drv(0, 0, 0, 0, 1, 0);
    idle(3);
    chk("R9 no busy", 32'(busy), 0);
    @(negedge clk) wp = 1'b0;
    drv(0, 0, 0, 0, 1, 0);
    idle(3);
    chk("R9 discarded", 32'(busy), 0);
    chk("R9 write count", 32'(wcount - w0), 0);

    // start discards
    w0 = wcount;
    drv(1, 16'h5000, 0, 0, 0, 0);
    drv(0, 0, 1, 8'h01, 0, 0);
    drv(0, 0, 0, 0, 0, 1);
    drv(0, 0, 0, 0, 1, 0);
    idle(3);
    chk("R10 no busy", 32'(busy), 0);
    chk("R10 write count", 32'(wcount - w0), 0);

    // byte and stop together
    w0 = wcount;
    drv(1, 16'h6000, 0, 0, 0, 0);
    drv(0, 0, 1, 8'h09, 0, 0);
    drv(0, 0, 1, 8'h99, 1, 0);
    idle(CYC + 5);
    chk("R11 write count", 32'(wcount - w0), 2);
    chk("R11 byte with stop", 32'(seen[16'h6001]), 32'h99);

    // protect raised inside a commit
    w0 = wcount;
    drv(1, 16'h7000, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) drv(0, 0, 1, 8'(8'hC0 + i), 0, 0);
    drv(0, 0, 0, 0, 1, 0);
    idle(1);
    @(negedge clk) wp = 1'b1;
    idle(CYC + 5);
    @(negedge clk) wp = 1'b0;
    idle(2);
    chk("R9 mid-commit writes", 32'(wcount - w0), 1);

    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule